// File: doc/BRIEF.md
# Parallel Configuration Port Abort Controller

This block is the slave side of a byte-wide parallel configuration port that runs on the configuration clock. A host selects the port with an active-low select and picks the transfer direction with a direction input. Low means write (configuration bytes flow in). High means read (readback bytes flow out from a ready/valid source). The controller tracks which kind of transfer is open. It hands accepted write bytes to a downstream consumer and drives readback bytes onto the bus with an output enable.

A host may abandon a transfer by flipping the direction input while the port is still selected. When a write is abandoned this way, the controller holds BUSY high and drives an 8-bit status word onto the data pins. That word carries an abort flag, a configuration-error flag, a sync-seen flag and a readback-history flag. When a read is abandoned, it holds BUSY high but leaves the bus undriven, because the direction input now marks the pins as inputs. Releasing the select ends any abort. The controller then goes back to idle, and the next selection opens a new transfer.

Top module: `cfgp_abort_ctrl`

## Requirements
- R1: After reset the port is idle: `busy`, `doe` and `wr_valid` are 0.
- R2: A write opens one clock after the port is selected with `dir_rd`=0. Each clock edge in an open write with `sel_n`=0 and `dir_rd`=0 accepts `din`. The byte appears on `wr_byte` with `wr_valid`=1 one clock later, in order, and `busy` stays 0 during the write.
- R3: A read opens one clock after the port is selected with `dir_rd`=1. While it is open, `rb_ready`=1 and `doe`=1, `dout` equals `rb_data`, and `busy` is the inverse of `rb_valid`.
- R4: If `dir_rd` falls while a read is open and `sel_n`=0, a readback abort starts at the next edge. `busy`=1 and `doe`=0 hold until `sel_n` rises, and no byte is accepted from `din` during the abort.
- R5: If `dir_rd` rises while a write is open and `sel_n`=0, a write abort starts at the next edge. `busy` stays 1 until release. The status word is driven (`doe`=1) whenever `dir_rd`=1, and the bus is released (`doe`=0) whenever `dir_rd`=0.
- R6: The status word places the abort flag (always 1) at bit 7, `cfg_err` at bit 6, `sync_seen` at bit 5 and the readback-history flag at bit 4. Bits 3:0 are 0, and the flags are sampled live.
- R7: Raising `sel_n` ends any abort. `busy` and `doe` fall in that same cycle, and the controller is idle after the next edge.
- R8: After an abort ends, a new selection opens a fresh transfer in the direction then chosen, with no state carried over from the abandoned transfer.
- R9: `doe` is 1 only when `sel_n`=0 and `dir_rd`=1. It stays 0 in the first selected cycle of a read, before the read has opened.
- R10: The readback-history flag (status bit 4) is 0 until a read has been opened since reset, and 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Port select, active low |
| dir_rd | input | 1 | Direction: 0 write, 1 read |
| din | input | 8 | Data pins as seen inbound |
| dout | output | 8 | Data pins driven outbound |
| doe | output | 1 | Output enable for the data pins |
| busy | output | 1 | Port busy indication |
| wr_byte | output | 8 | Accepted configuration byte |
| wr_valid | output | 1 | `wr_byte` holds a new byte this cycle |
| rb_data | input | 8 | Readback byte from the source |
| rb_valid | input | 1 | Readback source has a byte |
| rb_ready | output | 1 | Controller takes readback bytes |
| cfg_err | input | 1 | Configuration error flag for the status word |
| sync_seen | input | 1 | Sync word seen flag for the status word |

## Verification
Transfer state is registered, so an open transfer or an abort becomes visible at the first sampling point after the edge that follows the select or direction change. The combinational gates on `doe`, `dout` and `busy` respond within the same cycle the host changes `sel_n`, `dir_rd` or `rb_valid`. Accepted write bytes come out one clock after the edge that took them. The bench drives inputs on the falling edge and samples a moment later. It pushes each write byte into a queue when it drives it, and a falling-edge monitor pops the queue whenever `wr_valid` is 1. Any byte that appears during an abort therefore shows up as an unexpected pop.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WR   = 3'd1,
    ST_RD   = 3'd2,
    ST_WABT = 3'd3,
    ST_RABT = 3'd4
  } cfgp_state_e;

  localparam int unsigned FLAG_W = 4;

  // abort flag, error flag, sync flag, readback history, MSB first
  function automatic logic [FLAG_W-1:0] pack_flags(input logic err,
                                                   input logic sync,
                                                   input logic rb_hist);
    return {1'b1, err, sync, rb_hist};
  endfunction
endpackage

// File: rtl/cfgp_fsm.sv
module cfgp_fsm
  import cfgp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_n,
  input  logic        dir_rd,
  output cfgp_state_e st,
  output logic        wr_take,
  output logic        rd_live,
  output logic        wr_abort_evt,
  output logic        rd_abort_evt,
  output logic        rb_hist
);
  cfgp_state_e nxt;

  assign wr_take      = (st == ST_WR) && !sel_n && !dir_rd;
  assign rd_live      = (st == ST_RD) && !sel_n && dir_rd;
  assign wr_abort_evt = (st == ST_WR) && !sel_n && dir_rd;
  assign rd_abort_evt = (st == ST_RD) && !sel_n && !dir_rd;

  always_comb begin
    nxt = st;
    if (sel_n) begin
      nxt = ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: nxt = dir_rd ? ST_RD : ST_WR;
        ST_WR:   if (dir_rd)  nxt = ST_WABT;
        ST_RD:   if (!dir_rd) nxt = ST_RABT;
        default: nxt = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      rb_hist <= 1'b0;
    end else begin
      st <= nxt;
      if (st == ST_RD) rb_hist <= 1'b1;
    end
  end

  // R7
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> (st == ST_IDLE));
  // R8
  abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_WABT || st == ST_RABT) && !sel_n) |=> (st == $past(st)));
endmodule

// File: rtl/cfgp_wrcap.sv
module cfgp_wrcap #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_take,
  input  logic [DW-1:0] din,
  output logic          wr_valid,
  output logic [DW-1:0] wr_byte
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_byte  <= '0;
    end else begin
      wr_valid <= wr_take;
      if (wr_take) wr_byte <= din;
    end
  end

  // R2
  wr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> (wr_valid && wr_byte == $past(din)));
endmodule

// File: rtl/cfgp_bus.sv
module cfgp_bus
  import cfgp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cfgp_state_e   st,
  input  logic          sel_n,
  input  logic          dir_rd,
  input  logic          rd_live,
  input  logic          rb_hist,
  input  logic          cfg_err,
  input  logic          sync_seen,
  input  logic [DW-1:0] rb_data,
  input  logic          rb_valid,
  output logic [DW-1:0] dout,
  output logic          doe,
  output logic          busy,
  output logic          rb_ready
);
  localparam int unsigned PAD_W = DW - FLAG_W;

  logic          stat_drive;
  logic [DW-1:0] stat_word;

  assign stat_drive = (st == ST_WABT) && !sel_n && dir_rd;
  assign stat_word  = {pack_flags(cfg_err, sync_seen, rb_hist), {PAD_W{1'b0}}};

  assign doe      = rd_live || stat_drive;
  assign rb_ready = rd_live;

  always_comb begin
    if (stat_drive)   dout = stat_word;
    else if (rd_live) dout = rb_data;
    else              dout = '0;
  end

  always_comb begin
    unique case (st)
      ST_RD:            busy = !sel_n && !rb_valid;
      ST_WABT, ST_RABT: busy = !sel_n;
      default:          busy = 1'b0;
    endcase
  end

  // R9
  doe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doe |-> (!sel_n && dir_rd));
  // R4
  rabt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RABT) |-> !doe);
endmodule

// File: rtl/cfgp_abort_ctrl.sv
module cfgp_abort_ctrl
  import cfgp_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          dir_rd,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          doe,
  output logic          busy,
  output logic [DW-1:0] wr_byte,
  output logic          wr_valid,
  input  logic [DW-1:0] rb_data,
  input  logic          rb_valid,
  output logic          rb_ready,
  input  logic          cfg_err,
  input  logic          sync_seen
);
  cfgp_state_e st;
  logic wr_take, rd_live, wr_abort_evt, rd_abort_evt, rb_hist;

  cfgp_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .dir_rd(dir_rd),
    .st(st), .wr_take(wr_take), .rd_live(rd_live),
    .wr_abort_evt(wr_abort_evt), .rd_abort_evt(rd_abort_evt),
    .rb_hist(rb_hist)
  );

  cfgp_wrcap #(.DW(DW)) u_wrcap (
    .clk(clk), .rst_n(rst_n), .wr_take(wr_take), .din(din),
    .wr_valid(wr_valid), .wr_byte(wr_byte)
  );

  cfgp_bus #(.DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .st(st), .sel_n(sel_n), .dir_rd(dir_rd),
    .rd_live(rd_live), .rb_hist(rb_hist), .cfg_err(cfg_err),
    .sync_seen(sync_seen), .rb_data(rb_data), .rb_valid(rb_valid),
    .dout(dout), .doe(doe), .busy(busy), .rb_ready(rb_ready)
  );

  // R4
  rd_abort_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_abort_evt |=> (sel_n || (busy && !doe)));
  // R5
  wr_abort_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort_evt |=> (sel_n || !dir_rd || (busy && doe && dout[DW-1])));
  // R3
  rd_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_live && rb_valid) |-> (!busy && dout == rb_data));
  // R2
  wr_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> !busy);
endmodule

// File: tb/tb_cfgp_abort_ctrl.sv
module tb_cfgp_abort_ctrl;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_n = 1'b1, dir_rd = 1'b0;
  logic [7:0] din = '0, rb_data = '0;
  logic       rb_valid = 1'b0, cfg_err = 1'b0, sync_seen = 1'b0;
  logic [7:0] dout, wr_byte;
  logic       doe, busy, wr_valid, rb_ready;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  cfgp_abort_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .dir_rd(dir_rd), .din(din),
    .dout(dout), .doe(doe), .busy(busy), .wr_byte(wr_byte),
    .wr_valid(wr_valid), .rb_data(rb_data), .rb_valid(rb_valid),
    .rb_ready(rb_ready), .cfg_err(cfg_err), .sync_seen(sync_seen)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] status_exp(input logic e, input logic s, input logic h);
    logic [7:0] w = 8'h80;
    if (e) w = w + 8'h40;
    if (s) w = w + 8'h20;
    if (h) w = w + 8'h10;
    return w;
  endfunction

  task automatic nclk();
    @(negedge clk);
  endtask

  task automatic drive_wr(input logic [7:0] b);
    din = b;
    exp_q.push_back(b);
    nclk();
  endtask

  // monitor: R2 ordering, R4 no byte during abort
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R2/R4: unexpected byte actual %h expected none", wr_byte);
      end else begin
        chk("R2 write byte", wr_byte, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    nclk(); nclk();
    rst_n = 1'b1;
    #1;
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 doe", {7'd0, doe}, 8'd0);
    chk("R1 wr_valid", {7'd0, wr_valid}, 8'd0);
    nclk();

    // R2: write transfer
    sel_n = 1'b0; dir_rd = 1'b0;
    nclk();
    drive_wr(8'h11);
    #1 chk("R2 busy low in write", {7'd0, busy}, 8'd0);
    drive_wr(8'hA5);
    drive_wr(8'h00);
    drive_wr(8'hFF);

    // R5/R6: write abort
    cfg_err = 1'b1; sync_seen = 1'b1; dir_rd = 1'b1;
    #1 chk("R9 doe before abort edge", {7'd0, doe}, 8'd0);
    nclk(); #1;
    chk("R5 busy", {7'd0, busy}, 8'd1);
    chk("R5 doe", {7'd0, doe}, 8'd1);
    chk("R6 status err+sync", dout, status_exp(1'b1, 1'b1, 1'b0));
    nclk(); #1;
    chk("R5 status held", dout, status_exp(1'b1, 1'b1, 1'b0));
    dir_rd = 1'b0; din = 8'h3E;
    #1;
    chk("R5 doe off dir low", {7'd0, doe}, 8'd0);
    chk("R5 busy dir low", {7'd0, busy}, 8'd1);
    nclk();
    dir_rd = 1'b1; cfg_err = 1'b0;
    #1 chk("R6 status sync only", dout, status_exp(1'b0, 1'b1, 1'b0));
    sel_n = 1'b1;
    #1;
    chk("R7 busy on release", {7'd0, busy}, 8'd0);
    chk("R7 doe on release", {7'd0, doe}, 8'd0);
    nclk();

    // R8: fresh write after abort
    sel_n = 1'b0; dir_rd = 1'b0;
    nclk();
    drive_wr(8'h5A);
    sel_n = 1'b1;
    nclk(); nclk();

    // R3: readback
    sel_n = 1'b0; dir_rd = 1'b1;
    #1 chk("R9 doe first read cycle", {7'd0, doe}, 8'd0);
    nclk();
    rb_valid = 1'b1; rb_data = 8'h3C;
    #1;
    chk("R3 doe", {7'd0, doe}, 8'd1);
    chk("R3 dout", dout, 8'h3C);
    chk("R3 busy valid", {7'd0, busy}, 8'd0);
    chk("R3 rb_ready", {7'd0, rb_ready}, 8'd1);
    nclk();
    rb_valid = 1'b0;
    #1 chk("R3 busy idle source", {7'd0, busy}, 8'd1);
    nclk();
    rb_valid = 1'b1; rb_data = 8'hC3;
    #1 chk("R3 dout second", dout, 8'hC3);
    nclk();

    // R4: readback abort
    rb_valid = 1'b0; dir_rd = 1'b0; din = 8'h77;
    #1 chk("R9 doe dir low", {7'd0, doe}, 8'd0);
    nclk(); #1;
    chk("R4 busy", {7'd0, busy}, 8'd1);
    chk("R4 doe", {7'd0, doe}, 8'd0);
    nclk(); nclk(); #1;
    chk("R4 busy held", {7'd0, busy}, 8'd1);
    sel_n = 1'b1;
    #1 chk("R7 busy read release", {7'd0, busy}, 8'd0);
    nclk();

    // R10: history flag after read, R8 fresh write then abort
    sel_n = 1'b0; dir_rd = 1'b0; sync_seen = 1'b0;
    nclk();
    drive_wr(8'h42);
    dir_rd = 1'b1;
    nclk(); #1;
    chk("R10 status history", dout, status_exp(1'b0, 1'b0, 1'b1));
    sel_n = 1'b1;
    nclk(); nclk();

    chk("R2 queue drained", 8'(exp_q.size()), 8'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule